// File: doc/BRIEF.md
# Wave launch scalar register initializer

Before a wavefront starts executing, this block writes the launch-time values into its scalar register file. One start pulse captures a 15-bit enable mask together with the dispatch-wide values and the per-wave values. The dispatch-wide values are the scratch descriptor, four 64-bit pointers or IDs, the scratch init pair, the per-item scratch size and the grid and workgroup sizes. The per-wave values are the workgroup IDs, the workgroup info fields and the scratch wave offset. The block then walks a fixed list of fields. For every enabled register word it issues one register-file write per cycle, made of an index and 32 bits of data.

Enabled words are numbered densely from register 0. The dispatch-wide (user) region is capped at 16 registers. The per-wave (system) words follow directly after the last user word that was actually written. Before any write, the block computes the grid workgroup counts with a serial divider, and only when at least one of those counts will be written. It pulses done after the last write and holds the number of registers written, so that later logic can place the next free register.

Top module: `wave_sreg_init`

## Requirements
- R1: Enable bit i selects field i. Fields are visited in bit order, and each field uses the number of words given here. Bit 0 is the scratch descriptor (4 words). Bits 1 to 5 are the dispatch pointer, queue pointer, kernarg pointer, dispatch ID and scratch init pair (2 words each). Bit 6 is the private size (1 word). Bits 7 to 9 are the grid workgroup counts X, Y and Z. Bits 10 to 12 are the workgroup IDs X, Y and Z. Bit 13 is the workgroup info word. Bit 14 is the scratch wave offset. Bits 7 to 14 take 1 word each.
- R2: Writes carry indices 0, 1, 2 and so on, on consecutive cycles, with no gap. A disabled field consumes neither an index nor a cycle.
- R3: A multi-word field is written with its least significant 32 bits first, at the lowest index of that field. The scratch descriptor word k is bits [32k+31:32k].
- R4: No user word (bits 0 to 9) is written at index 16 or above, and such words are dropped. The system words (bits 10 to 14) start right after the last user word written.
- R5: The grid workgroup count for a dimension is ceil(grid / workgroup size). A workgroup size of 0 gives a count of 0.
- R6: The workgroup info word is {first wave flag at bit 31, bits 30..17 zero, ordered append term at bits 16..6, waves per group at bits 5..0}.
- R7: The private size word is the requested byte size rounded up to the next multiple of 4.
- R8: Enabling workgroup ID Z (bit 12) also writes workgroup ID Y, even when bit 11 is clear.
- R9: done is high for exactly one cycle, in the cycle after the last write. With no field enabled, done is high in the cycle right after start is sampled.
- R10: After reset, wrValid, done and regCount are 0. When done is high, regCount equals the number of writes made by that launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures all inputs and begins a launch (honoured while idle) |
| enMask | input | 15 | Field enables, bit order as in R1 |
| privBuf | input | 128 | Scratch descriptor, four words |
| dispatchPtr | input | 64 | Dispatch packet address |
| queuePtr | input | 64 | Queue object address |
| kernargPtr | input | 64 | Kernel argument block address |
| dispatchId | input | 64 | Dispatch identifier |
| flatScratch | input | 64 | Scratch init pair, offset in low word, size in high word |
| privSize | input | 32 | Requested per-item scratch bytes |
| gridX | input | 32 | Grid size X in items |
| gridY | input | 32 | Grid size Y in items |
| gridZ | input | 32 | Grid size Z in items |
| grpX | input | 32 | Workgroup size X in items |
| grpY | input | 32 | Workgroup size Y in items |
| grpZ | input | 32 | Workgroup size Z in items |
| wgIdX | input | 32 | Workgroup ID X of this wave |
| wgIdY | input | 32 | Workgroup ID Y of this wave |
| wgIdZ | input | 32 | Workgroup ID Z of this wave |
| firstWave | input | 1 | First wave of its group |
| orderedAppend | input | 11 | Ordered append term |
| tgWaves | input | 6 | Waves per workgroup |
| waveOffset | input | 32 | Scratch wave byte offset |
| wrValid | output | 1 | Write strobe to the register file |
| wrIdx | output | 5 | Destination register index |
| wrData | output | 32 | Value to write |
| done | output | 1 | One-cycle pulse after the last write |
| regCount | output | 5 | Registers written by the launch |

## Verification
The hardest case to reach is the user-region cap. The cap needs more than 16 enabled user words, which happens only when nearly every dispatch-wide field is on. The trailing grid counts then fall on indices 16 and 17, must vanish, and must not delay the system words. One scenario enables all fifteen fields. It expects the private size and the X count to land on indices 14 and 15 and the workgroup ID X word to land on index 16. A second scenario enables only ID Z, to show that ID Y is forced in. A third uses a zero workgroup size and sizes that do not divide evenly, so the serial divider runs before the first write.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_FIELDS = 15;
  localparam int NUM_SLOTS  = 23;   // word slots over all fields
  localparam int USER_SLOTS = 18;   // slots 0..17 are dispatch-wide
  localparam int NUM_SYS    = NUM_SLOTS - USER_SLOTS;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);

  // field owning a word slot
  function automatic int slotField(int s);
    if (s < 4)       return 0;
    else if (s < 14) return 1 + (s - 4) / 2;
    else             return s - 8;
  endfunction

  typedef struct packed {
    logic              latch;
    logic              divGo;
    logic [SLOT_W-1:0] slot;
  } ctlStrobe_t;
endpackage

// File: rtl/wsi_ceildiv.sv
module wsi_ceildiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W:0]   num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] result
);
  localparam int N  = W + 1;
  localparam int CW = $clog2(N + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W:0]    rem, shifted, remNext;
  logic [N-1:0]  quo;
  logic [W-1:0]  denQ;
  logic          denZero, ge;

  always_comb begin
    shifted = {rem[W-1:0], quo[N-1]};
    ge      = shifted >= {1'b0, denQ};
    remNext = ge ? shifted - {1'b0, denQ} : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; cnt <= '0; rem <= '0; quo <= '0;
      denQ <= '0; denZero <= 1'b0; fin <= 1'b0;
    end else if (go) begin
      busy <= 1'b1; cnt <= '0; rem <= '0; quo <= num;
      denQ <= den; denZero <= (den == '0); fin <= 1'b0;
    end else if (busy) begin
      rem <= remNext;
      quo <= {quo[N-2:0], ge};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(N - 1)) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign result = denZero ? '0 : quo[W-1:0];

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !denZero |-> !rem[W] && (rem < {1'b0, denQ}));
  // R5
  quo_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fin |-> (denZero || !quo[N-1]));
endmodule

// File: rtl/wsi_datapath.sv
module wsi_datapath
  import wsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [127:0]      privBuf,
  input  logic [63:0]       dispatchPtr,
  input  logic [63:0]       queuePtr,
  input  logic [63:0]       kernargPtr,
  input  logic [63:0]       dispatchId,
  input  logic [63:0]       flatScratch,
  input  logic [31:0]       privSize,
  input  logic [3*DATA_W-1:0] gridIn,
  input  logic [3*DATA_W-1:0] grpIn,
  input  logic [3*DATA_W-1:0] wgIdIn,
  input  logic              firstWave,
  input  logic [10:0]       orderedAppend,
  input  logic [5:0]        tgWaves,
  input  logic [31:0]       waveOffset,
  output logic [DATA_W-1:0] wrData,
  output logic              cntReady
);
  logic [127:0]            bufQ;
  logic [4:0][63:0]        ptrQ;
  logic [31:0]             sizeQ, offQ;
  logic [2:0][DATA_W-1:0]  gridQ, grpQ, idQ, cntQ;
  logic [31:0]             infoQ;
  logic                    kick, divFin;
  logic [1:0]              dim;
  logic [DATA_W:0]         divNum;
  logic [DATA_W-1:0]       divRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ <= '0; ptrQ <= '0; sizeQ <= '0; offQ <= '0;
      gridQ <= '0; grpQ <= '0; idQ <= '0; infoQ <= '0;
    end else if (ctl.latch) begin
      bufQ  <= privBuf;
      ptrQ  <= {flatScratch, dispatchId, kernargPtr, queuePtr, dispatchPtr};
      sizeQ <= (privSize + 32'd3) & ~32'd3;
      offQ  <= waveOffset;
      gridQ <= gridIn;
      grpQ  <= grpIn;
      idQ   <= wgIdIn;
      infoQ <= {firstWave, 14'd0, orderedAppend, tgWaves};
    end
  end

  // three divides in sequence, one per dimension
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kick <= 1'b0; dim <= '0; cntQ <= '0;
    end else begin
      kick <= 1'b0;
      if (ctl.divGo) begin
        kick <= 1'b1;
        dim  <= '0;
      end else if (divFin) begin
        cntQ[dim] <= divRes;
        if (dim != 2'd2) begin
          dim  <= dim + 1'b1;
          kick <= 1'b1;
        end
      end
    end
  end

  assign divNum   = {1'b0, gridQ[dim]} + {1'b0, grpQ[dim]} - 1'b1;
  assign cntReady = divFin && (dim == 2'd2);

  wsi_ceildiv #(.W(DATA_W)) uDiv (
    .clk(clk), .rstN(rstN), .go(kick), .num(divNum), .den(grpQ[dim]),
    .fin(divFin), .result(divRes)
  );

  always_comb begin
    case (ctl.slot)
      5'd0:  wrData = bufQ[31:0];
      5'd1:  wrData = bufQ[63:32];
      5'd2:  wrData = bufQ[95:64];
      5'd3:  wrData = bufQ[127:96];
      5'd4:  wrData = ptrQ[0][31:0];
      5'd5:  wrData = ptrQ[0][63:32];
      5'd6:  wrData = ptrQ[1][31:0];
      5'd7:  wrData = ptrQ[1][63:32];
      5'd8:  wrData = ptrQ[2][31:0];
      5'd9:  wrData = ptrQ[2][63:32];
      5'd10: wrData = ptrQ[3][31:0];
      5'd11: wrData = ptrQ[3][63:32];
      5'd12: wrData = ptrQ[4][31:0];
      5'd13: wrData = ptrQ[4][63:32];
      5'd14: wrData = sizeQ;
      5'd15: wrData = cntQ[0];
      5'd16: wrData = cntQ[1];
      5'd17: wrData = cntQ[2];
      5'd18: wrData = idQ[0];
      5'd19: wrData = idQ[1];
      5'd20: wrData = idQ[2];
      5'd21: wrData = infoQ;
      5'd22: wrData = offQ;
      default: wrData = '0;
    endcase
  end

  // R5
  div_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntReady |=> !cntReady && !kick);
endmodule

// File: rtl/wsi_ctrl.sv
module wsi_ctrl
  import wsi_pkg::*;
#(
  parameter int USER_CAP = 16,
  parameter int IDX_W    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_FIELDS-1:0] enMask,
  input  logic                  cntReady,
  output ctlStrobe_t            ctl,
  output logic                  wrValid,
  output logic [IDX_W-1:0]      wrIdx,
  output logic                  done,
  output logic [IDX_W-1:0]      regCount
);
  typedef enum logic [1:0] {IDLE, DIV, EMIT, FIN} state_t;

  state_t                 state;
  logic [NUM_SLOTS-1:0]   elig, pending;
  logic [NUM_FIELDS-1:0]  effEn;
  logic [SLOT_W-1:0]      curSlot;
  logic [IDX_W-1:0]       writeCnt;
  logic                   needDiv, pendLast, accept;
  int                     used;

  always_comb begin
    effEn     = enMask;
    effEn[11] = enMask[11] | enMask[12];
    elig = '0;
    used = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (effEn[slotField(s)]) begin
        if (s >= USER_SLOTS) elig[s] = 1'b1;
        else if (used < USER_CAP) begin
          elig[s] = 1'b1;
          used    = used + 1;
        end
      end
    end
    needDiv = |elig[USER_SLOTS-1:USER_SLOTS-3];
  end

  always_comb begin
    curSlot = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (pending[s]) curSlot = SLOT_W'(s);
    pendLast = (pending & (pending - 1'b1)) == '0;
  end

  assign accept = (state == IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE; pending <= '0; writeCnt <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          pending  <= elig;
          writeCnt <= '0;
          if (needDiv)           state <= DIV;
          else if (elig == '0)   state <= FIN;
          else                   state <= EMIT;
        end
        DIV:  if (cntReady) state <= EMIT;
        EMIT: begin
          pending[curSlot] <= 1'b0;
          writeCnt         <= writeCnt + 1'b1;
          if (pendLast) state <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign ctl.latch = accept;
  assign ctl.divGo = accept && needDiv;
  assign ctl.slot  = curSlot;
  assign wrValid   = (state == EMIT);
  assign wrIdx     = writeCnt;
  assign done      = (state == FIN);
  assign regCount  = writeCnt;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && $past(wrValid) |-> wrIdx == $past(wrIdx) + 1'b1);
  // R1
  slot_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && $past(wrValid) |-> curSlot > $past(curSlot));
  // R4
  user_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (curSlot < SLOT_W'(USER_SLOTS)) |-> wrIdx < IDX_W'(USER_CAP));
endmodule

// File: rtl/wave_sreg_init.sv
module wave_sreg_init
  import wsi_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int IDX_W   = $clog2(USER_CAP + NUM_SYS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_FIELDS-1:0] enMask,
  input  logic [127:0]          privBuf,
  input  logic [63:0]           dispatchPtr,
  input  logic [63:0]           queuePtr,
  input  logic [63:0]           kernargPtr,
  input  logic [63:0]           dispatchId,
  input  logic [63:0]           flatScratch,
  input  logic [31:0]           privSize,
  input  logic [31:0]           gridX,
  input  logic [31:0]           gridY,
  input  logic [31:0]           gridZ,
  input  logic [31:0]           grpX,
  input  logic [31:0]           grpY,
  input  logic [31:0]           grpZ,
  input  logic [31:0]           wgIdX,
  input  logic [31:0]           wgIdY,
  input  logic [31:0]           wgIdZ,
  input  logic                  firstWave,
  input  logic [10:0]           orderedAppend,
  input  logic [5:0]            tgWaves,
  input  logic [31:0]           waveOffset,
  output logic                  wrValid,
  output logic [IDX_W-1:0]      wrIdx,
  output logic [DATA_W-1:0]     wrData,
  output logic                  done,
  output logic [IDX_W-1:0]      regCount
);
  ctlStrobe_t ctl;
  logic       cntReady;

  wsi_ctrl #(.USER_CAP(USER_CAP), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .enMask(enMask),
    .cntReady(cntReady), .ctl(ctl), .wrValid(wrValid), .wrIdx(wrIdx),
    .done(done), .regCount(regCount)
  );

  wsi_datapath uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .privBuf(privBuf),
    .dispatchPtr(dispatchPtr), .queuePtr(queuePtr), .kernargPtr(kernargPtr),
    .dispatchId(dispatchId), .flatScratch(flatScratch), .privSize(privSize),
    .gridIn({gridZ, gridY, gridX}), .grpIn({grpZ, grpY, grpX}),
    .wgIdIn({wgIdZ, wgIdY, wgIdX}), .firstWave(firstWave),
    .orderedAppend(orderedAppend), .tgWaves(tgWaves), .waveOffset(waveOffset),
    .wrData(wrData), .cntReady(cntReady)
  );
endmodule

// File: tb/wave_sreg_init_test.sv
module wave_sreg_init_test;
  logic clk = 0, rstN = 0, start = 0;
  logic [14:0] en = '0;
  logic [127:0] privBuf;
  logic [63:0] dPtr, qPtr, kPtr, dId, fScr;
  logic [31:0] pSize, gX, gY, gZ, sX, sY, sZ, iX, iY, iZ, wOff;
  logic fWave; logic [10:0] oAppend; logic [5:0] tgw;
  logic wrValid, done; logic [4:0] wrIdx, regCount; logic [31:0] wrData;

  always #5 clk = ~clk;

  wave_sreg_init uut (
    .clk(clk), .rstN(rstN), .start(start), .enMask(en), .privBuf(privBuf),
    .dispatchPtr(dPtr), .queuePtr(qPtr), .kernargPtr(kPtr), .dispatchId(dId),
    .flatScratch(fScr), .privSize(pSize), .gridX(gX), .gridY(gY), .gridZ(gZ),
    .grpX(sX), .grpY(sY), .grpZ(sZ), .wgIdX(iX), .wgIdY(iY), .wgIdZ(iZ),
    .firstWave(fWave), .orderedAppend(oAppend), .tgWaves(tgw),
    .waveOffset(wOff), .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData),
    .done(done), .regCount(regCount)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor, sampling at the falling edge
  int gotN, gotCyc[32], doneCyc, startCyc; bit doneSeen;
  logic [4:0] gotIdx[32], doneCount; logic [31:0] gotData[32];
  always @(negedge clk) begin
    if (wrValid && gotN < 32) begin
      gotIdx[gotN] = wrIdx; gotData[gotN] = wrData; gotCyc[gotN] = cyc;
      gotN = gotN + 1;
    end
    if (done && !doneSeen) begin
      doneSeen = 1; doneCyc = cyc; doneCount = regCount;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ceilDiv(logic [31:0] g, logic [31:0] s);
    longint q;
    if (s == 0) return 0;
    q = (longint'(g) + longint'(s) - 1) / longint'(s);
    return q[31:0];
  endfunction

  // expected list from the requirements
  int expN; logic [31:0] expData[32]; int expSlot[32];
  function automatic logic [31:0] slotWord(int s);
    case (s)
      0,1,2,3: return privBuf[32*s +: 32];
      4: return dPtr[31:0];  5: return dPtr[63:32];
      6: return qPtr[31:0];  7: return qPtr[63:32];
      8: return kPtr[31:0];  9: return kPtr[63:32];
      10: return dId[31:0];  11: return dId[63:32];
      12: return fScr[31:0]; 13: return fScr[63:32];
      14: return (pSize + 3) & ~32'd3;
      15: return ceilDiv(gX, sX);
      16: return ceilDiv(gY, sY);
      17: return ceilDiv(gZ, sZ);
      18: return iX; 19: return iY; 20: return iZ;
      21: return {fWave, 14'd0, oAppend, tgw};
      default: return wOff;
    endcase
  endfunction

  function automatic int fieldOf(int s);
    if (s < 4) return 0;
    if (s < 14) return 1 + (s - 4) / 2;
    return s - 8;
  endfunction

  function automatic string tagOf(int s);
    if (s < 14) return "R3";
    if (s == 14) return "R7";
    if (s < 18) return "R5";
    if (s == 21) return "R6";
    return "R1";
  endfunction

  task automatic buildExp();
    logic [14:0] e; int users;
    e = en; if (en[12]) e[11] = 1'b1;   // R8
    expN = 0; users = 0;
    for (int s = 0; s < 23; s++) begin
      if (e[fieldOf(s)] && (s >= 18 || users < 16)) begin
        if (s < 18) users++;
        expData[expN] = slotWord(s); expSlot[expN] = s; expN++;
      end
    end
  endtask

  task automatic runLaunch(bit noDivide);
    buildExp();
    @(negedge clk);
    gotN = 0; doneSeen = 0;
    start = 1; startCyc = cyc;
    @(negedge clk); start = 0;
    for (int t = 0; t < 2000 && !doneSeen; t++) @(negedge clk);
    check("R9 done reached", doneSeen, 1);
    check("R2 write count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++) begin
      check("R2 index", gotIdx[i], i);
      check(tagOf(expSlot[i]), gotData[i], expData[i]);
      check("R2 back-to-back", gotCyc[i], gotCyc[0] + i);
    end
    if (gotN > 0) check("R9 done after last write", doneCyc, gotCyc[gotN-1] + 1);
    if (noDivide) check("R9 done latency", doneCyc - startCyc, expN + 1);
    check("R10 regCount at done", doneCount, expN);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
  endtask

  task automatic setValues(int seed);
    privBuf = {32'hA0A0_0003 + seed, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000 ^ seed};
    dPtr = 64'h1111_2222_3333_4444 + seed; qPtr = 64'h5555_6666_7777_8888;
    kPtr = 64'h9999_AAAA_BBBB_CCCC; dId = 64'hDDDD_EEEE_FFFF_0001 + seed;
    fScr = 64'h0000_0040_0000_1000;
    pSize = 32'd13; gX = 32'd100; gY = 32'd64; gZ = 32'd7;
    sX = 32'd16; sY = 32'd64; sZ = 32'd3;
    iX = 32'h10 + seed; iY = 32'h20; iZ = 32'h30;
    fWave = 1; oAppend = 11'h5A5; tgw = 6'd37; wOff = 32'hCAFE_0000 + seed;
  endtask

  task automatic testReset();
    check("R10 reset wrValid", wrValid, 0);
    check("R10 reset done", done, 0);
    check("R10 reset regCount", regCount, 0);
  endtask

  task automatic testEmpty();  // R9 no field: done right after start
    setValues(1); en = '0; runLaunch(1);
  endtask

  task automatic testAll();    // R4 cap with every field enabled
    setValues(2); en = 15'h7FFF; runLaunch(0);
    check("R4 total with cap", gotN, 21);
    if (gotN > 16) begin
      check("R4 wgid X lands at 16", gotData[16], iX);
      check("R4 gridcount X at 15", gotData[15], ceilDiv(gX, sX));
    end
  endtask

  task automatic testSparse(); // R8 Z forces Y, R1 dense order
    setValues(3); en = '0; en[1] = 1; en[3] = 1; en[12] = 1; runLaunch(1);
    if (gotN == 6) begin
      check("R8 forced Y at 4", gotData[4], iY);
      check("R8 Z at 5", gotData[5], iZ);
      check("R3 kernarg low at 2", gotData[2], kPtr[31:0]);
    end
  endtask

  task automatic testDivide(); // R5 zero size, uneven sizes; R7 rounding
    setValues(4); sY = 0; gZ = 32'hFFFF_FFFF; sZ = 32'd1; pSize = 32'd16;
    en = '0; en[6] = 1; en[7] = 1; en[8] = 1; en[9] = 1; runLaunch(0);
    if (gotN == 4) begin
      check("R5 zero size", gotData[2], 0);
      check("R5 ceil 100/16", gotData[1], 7);
      check("R5 max by one", gotData[3], 32'hFFFF_FFFF);
      check("R7 already aligned", gotData[0], 16);
    end
  endtask

  task automatic testSystem(); // R6 info layout alone
    setValues(5); fWave = 0; oAppend = 11'h7FF; tgw = 6'h3F;
    en = '0; en[13] = 1; en[14] = 1; en[0] = 1; runLaunch(1);
    if (gotN == 6) check("R6 info word", gotData[4], 32'h0001_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    testEmpty();
    testAll();
    testSparse();
    testDivide();
    testSystem();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule